// File: doc/BRIEF.md
# Signed BCD Up/Down Results Counter

This block keeps a five-digit decimal running total while a conversion measures its charge-removal intervals. On each enabled clock it adds or removes one unit at a chosen decade (ones, tens or hundreds), with the direction given by the polarity of the interval in progress. Decimal carries and borrows pass through every digit. A negative total is not held with a separate sign. It wraps modulo 100,000, so it reads as the ten's-complement decimal pattern.

A sequencer supplies the strobes. A clear pulse at the start of a conversion zeroes the running total. A transfer pulse at the end of the conversion copies the total into a holding register that software reads as five 4-bit BCD digits. The holding register keeps its value between transfers while the next conversion accumulates.

Top module: `bcd_updown_acc`

## Requirements
- R1: After reset is asserted, both the running total and `result` are 00000.
- R2: When `clr` is high at a clock edge, the running total is 00000 after that edge, even if `cnt_en` is high in the same cycle.
- R3: When `cnt_en` is high, the total changes by 1 for `weight` = 2'b00, by 10 for 2'b01 and by 100 for 2'b10.
- R4: With `cnt_down` = 0 an enabled step adds to the total. With `cnt_down` = 1 it subtracts.
- R5: Carries and borrows pass through all five digits, and the total wraps modulo 100,000. For example, 999 + 1 gives 01000 and 99999 + 1 gives 00000.
- R6: Negative totals read as value + 100,000 in BCD. For example, -1 reads 99999 and -25,000 reads 75000.
- R7: When `xfer` is high at a clock edge, `result` takes the total as it stood before that edge. Otherwise `result` holds. A `clr` in the same cycle does not change what is copied.
- R8: When `cnt_en` is low, or `weight` is 2'b11, the total does not change.
- R9: Every 4-bit digit of the total is always in the range 0 to 9.
- `result[3:0]` holds the ones digit, and each higher nibble holds the next decade.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Zeroes the running total (start of conversion) |
| cnt_en | input | 1 | Step the running total this cycle |
| cnt_down | input | 1 | 1 = subtract, 0 = add |
| weight | input | 2 | Decade of the step: 00 ones, 01 tens, 10 hundreds, 11 no step |
| xfer | input | 1 | Copy the running total into `result` (end of conversion) |
| result | output | 20 | Held total, five BCD digits, ones digit in bits 3:0 |

## Verification
The running total can only be seen through `result`, one edge after a transfer. A wrong digit update or a lost carry therefore shows at the ports one cycle after the next `xfer`, not at the moment it happens. The bench places a transfer right after each short stimulus so that a fault shows within a few cycles. It also uses boundary totals (999, 00000 going down, 99999 going up) where a broken carry or borrow changes several digits at once. The bound checker watches the internal total every cycle, for the clear, for digit range and for holding.

// File: rtl/bcd_updown_acc.sv
module bcd_updown_acc #(
  parameter int DIGITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                cnt_en,
  input  logic                cnt_down,
  input  logic [1:0]          weight,
  input  logic                xfer,
  output logic [4*DIGITS-1:0] result
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0]    acc;
  logic [W-1:0]    acc_nxt;
  logic [DIGITS:0] cy;
  logic            step;

  assign step  = cnt_en && (weight != 2'b11);
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic       inc;
    logic [4:0] sum;
    logic [4:0] dif;
    assign inc = step && (int'(weight) == i);
    assign sum = {1'b0, acc[4*i +: 4]} + {4'b0, inc} + {4'b0, cy[i]};
    assign dif = {1'b0, acc[4*i +: 4]} - {4'b0, inc} - {4'b0, cy[i]};
    always_comb begin
      if (cnt_down) begin
        cy[i+1]          = dif[4];
        acc_nxt[4*i +: 4] = dif[4] ? 4'(dif + 5'd10) : dif[3:0];
      end else begin
        cy[i+1]          = (sum > 5'd9);
        acc_nxt[4*i +: 4] = (sum > 5'd9) ? 4'(sum - 5'd10) : sum[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (step)   acc <= acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result <= '0;
    else if (xfer)   result <= acc;
  end
endmodule

// File: rtl/bcd_updown_acc_chk.sv
module bcd_updown_acc_chk #(
  parameter int DIGITS = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic                cnt_en,
  input logic [1:0]          weight,
  input logic                xfer,
  input logic [4*DIGITS-1:0] acc,
  input logic [4*DIGITS-1:0] result
);
  function automatic bit digits_ok(input logic [4*DIGITS-1:0] v);
    bit ok = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc == '0);

  // R7
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> result == $past(acc));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(result));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (!cnt_en || weight == 2'b11)) |=> $stable(acc));

  // R9
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digits_ok(acc) && digits_ok(result));
endmodule

bind bcd_updown_acc bcd_updown_acc_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/tb_bcd_updown_acc.sv
module tb_bcd_updown_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, cnt_en = 1'b0, cnt_down = 1'b0, xfer = 1'b0;
  logic [1:0]  weight = 2'b00;
  logic [19:0] result;
  int          n_chk = 0, n_fail = 0;
  int          model = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  bcd_updown_acc dut (.*);

  function automatic logic [19:0] to_bcd(input int v);
    logic [19:0] r;
    int u = ((v % 100000) + 100000) % 100000;
    for (int k = 0; k < 5; k++) begin
      r[4*k +: 4] = 4'(u % 10);
      u = u / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [19:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: result=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic steps(input int n, input logic [1:0] w, input logic dn);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cnt_en = 1'b1; weight = w; cnt_down = dn;
      if (w != 2'b11) model += (dn ? -1 : 1) * (w == 2'b00 ? 1 : w == 2'b01 ? 10 : 100);
    end
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic do_xfer();
    @(negedge clk); xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1; model = 0;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset result", 20'h00000);
    do_xfer();
    check("R1 reset total", 20'h00000);
  endtask

  task automatic t_weights();
    steps(7, 2'b00, 1'b0); steps(3, 2'b01, 1'b0); steps(2, 2'b10, 1'b0);
    do_xfer();
    check("R3 R4 weighted up 237", to_bcd(237));
    steps(5, 2'b00, 1'b0);
    check("R7 result holds", to_bcd(237));
    do_xfer();
    check("R7 transfer 242", to_bcd(242));
    steps(4, 2'b01, 1'b1);
    do_xfer();
    check("R4 down tens 202", to_bcd(model));
  endtask

  task automatic t_clear();
    do_clr(); do_xfer();
    check("R2 clear", 20'h00000);
    steps(3, 2'b00, 1'b0);
    @(negedge clk); clr = 1'b1; cnt_en = 1'b1; weight = 2'b10; model = 0;
    @(negedge clk); clr = 1'b0; cnt_en = 1'b0;
    do_xfer();
    check("R2 clear beats count", 20'h00000);
  endtask

  task automatic t_wrap();
    do_clr();
    steps(1, 2'b00, 1'b1); do_xfer();
    check("R6 minus one", 20'h99999);
    steps(1, 2'b00, 1'b0); do_xfer();
    check("R5 99999+1 wraps", 20'h00000);
    steps(9, 2'b10, 1'b0); steps(9, 2'b01, 1'b0); steps(9, 2'b00, 1'b0);
    steps(1, 2'b00, 1'b0); do_xfer();
    check("R5 999+1 carry", 20'h01000);
    steps(1, 2'b00, 1'b1); do_xfer();
    check("R5 1000-1 borrow", 20'h00999);
    do_clr();
    steps(250, 2'b10, 1'b1); do_xfer();
    check("R6 minus 25000", 20'h75000);
  endtask

  task automatic t_ignore();
    do_clr(); steps(4, 2'b00, 1'b0); do_xfer();
    @(negedge clk); cnt_en = 1'b0; weight = 2'b10; cnt_down = 1'b0;
    repeat (3) @(negedge clk);
    do_xfer();
    check("R8 enable low", to_bcd(4));
    steps(6, 2'b11, 1'b0); do_xfer();
    check("R8 weight 11 no step", to_bcd(4));
  endtask

  task automatic t_xfer_clr();
    steps(2, 2'b01, 1'b0);
    @(negedge clk); xfer = 1'b1; clr = 1'b1;
    @(negedge clk); xfer = 1'b0; clr = 1'b0;
    check("R7 xfer with clr copies old", to_bcd(24));
    model = 0; do_xfer();
    check("R2 total cleared", 20'h00000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_weights(); t_clear(); t_wrap(); t_ignore(); t_xfer_clr();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule